// File: doc/BRIEF.md
# Conversion Mode Sequencer with Ready and Error Flags

This block decides when a sigma-delta converter runs and when a finished result is placed into its data register. It also maintains the two status flags that software polls: a ready flag, which is active low, and an error flag. A small counter of conversion-period ticks stands in for the modulator and digital filter. The sample value and the out-of-range indications come in on input ports. The block supports three operating modes: free-running conversion, one-shot conversion that powers down afterwards, and standby.

A filter that has just been restarted needs two conversion periods to settle. After that, a continuous stream delivers one result per period. When the period that completes a conversion ends, the ready flag goes high. The new result is then loaded a fixed number of clock cycles later, and the flag drops at that moment. This guard window tells readers not to start a read that would straddle the update. Reading the data register raises the flag again, so each result is presented once. Writing the mode register restarts the settling sequence and cancels any load that is still pending.

Top module: `conv_seq`

## Requirements
- R1: `mode_bits` encodes the operating mode: 2'b00 is continuous, 2'b01 is single, and 2'b10 or 2'b11 is standby. The mode is captured on a `mode_wr` pulse. After reset the block is in continuous mode with `pwr_on`=1, `rdy`=1, `err`=0 and `data_out`=0.
- R2: After a restart, the first period tick produces no result. The second period tick produces the first result.
- R3: Once the first result has been delivered in continuous mode, every further period tick produces exactly one more load.
- R4: `rdy` goes high on the clock edge that samples the completing tick. `load_stb` is high for one cycle. On the edge GUARD_CYC cycles after that tick, `data_out` takes the new result and `rdy` goes low.
- R5: In single mode, `pwr_on` stays high until the load and goes low on the load edge. Later ticks cause no load. The result and the low `rdy` are held until a read.
- R6: A `data_rd` pulse sets `rdy` on the next edge and leaves `data_out` unchanged.
- R7: A `mode_wr` pulse sets `rdy`, cancels any pending load, and restarts the two-tick settling count.
- R8: In standby, `pwr_on` is low, `rdy` stays high, ticks cause no load, and `data_out` is unchanged.
- R9: At a load, `ovr_hi` stores all ones and `ovr_lo` stores all zeros. If both are set, `ovr_hi` wins. Either one sets `err`. An in-range load stores `conv_data` and clears `err`.
- R10: A mode write that selects continuous or single mode clears `err`. A mode write that selects standby leaves `err` unchanged.
- R11: If a load and a read fall in the same cycle, the load wins and `rdy` ends low. If a mode write falls while a load is pending, no load takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_bits | input | 2 | Mode value written with `mode_wr` |
| period_tick | input | 1 | One pulse per conversion period |
| data_rd | input | 1 | Data register read strobe |
| ovr_hi | input | 1 | Result above full scale |
| ovr_lo | input | 1 | Result below zero scale |
| conv_data | input | DW | Raw conversion result |
| pwr_on | output | 1 | Converter powered and converting |
| load_stb | output | 1 | Data register loads at the next edge |
| data_out | output | DW | Data register |
| rdy | output | 1 | Ready flag, low while an unread result is held |
| err | output | 1 | Last stored result was clamped |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a read strobe and the final cycle of the guard window. The bench raises `data_rd` exactly while `load_stb` is high, then expects the new value in `data_out` with `rdy` low. The second pair is a mode write and a load that is still pending. The bench writes the mode inside the guard window, then expects that no load ever occurs, the old data remains, and `rdy` stays high.

// File: rtl/conv_seq_pkg.sv
// Package: shared state type and mode decoding for the conversion sequencer.
// Assumes a two-bit mode field where any value with the top bit set means standby.
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_STBY   = 2'd0,
        ST_CONT   = 2'd1,
        ST_SINGLE = 2'd2,
        ST_SDONE  = 2'd3
    } seq_state_t;

    localparam logic [1:0] MODE_CONT   = 2'b00;
    localparam logic [1:0] MODE_SINGLE = 2'b01;

    // Map a written mode field onto the state it starts.
    function automatic seq_state_t decode_mode(input logic [1:0] m);
        if (m == MODE_CONT)        return ST_CONT;
        else if (m == MODE_SINGLE) return ST_SINGLE;
        else                       return ST_STBY;
    endfunction

endpackage

// File: rtl/conv_seq_settle.sv
// Settling counter: stands in for the modulator and filter.
// Counts period ticks after a restart and reports a finished conversion
// from tick FIRST_TICKS onward, one per tick.
// Assumes FIRST_TICKS >= 1. The count is cleared while not running.
module conv_seq_settle #(
    parameter int FIRST_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(FIRST_TICKS) + 1;
    localparam logic [CW-1:0] LAST = CW'(FIRST_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Advance the settle count on each tick until it saturates.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (restart || !run)         cnt_q <= '0;
        else if (tick && (cnt_q != LAST)) cnt_q <= cnt_q + 1'b1;
    end

    // A tick that arrives at the saturated count completes a conversion.
    always_comb done = run && !restart && tick && (cnt_q == LAST);

endmodule

// File: rtl/conv_seq_guard.sv
// Guard timer: holds a completed conversion back for GUARD_CYC cycles before
// the load. Completions that arrive while a window is open are ignored.
// A restart closes the window without firing.
// Assumes GUARD_CYC >= 1.
module conv_seq_guard #(
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic done,
    output logic arm,
    output logic fire
);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] GLOAD = GW'(GUARD_CYC);

    logic [GW-1:0] gcnt_q;

    // Accept a completion only when no window is open.
    always_comb arm  = done && !restart && (gcnt_q == '0);
    // The last cycle of the window triggers the load.
    always_comb fire = (gcnt_q == GW'(1)) && !restart;

    // Open, count down, or cancel the guard window.
    always_ff @(posedge clk) begin
        if (!rst_n)              gcnt_q <= '0;
        else if (restart)        gcnt_q <= '0;
        else if (arm)            gcnt_q <= GLOAD;
        else if (gcnt_q != '0)   gcnt_q <= gcnt_q - 1'b1;
    end

endmodule

// File: rtl/conv_seq_result.sv
// Result register: on a load it stores the raw value, or the saturated value
// when the converter reports an out-of-range input. Over-range wins over
// under-range. It also reports whether the incoming value is being clamped.
module conv_seq_result #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          ovr_hi,
    input  logic          ovr_lo,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          clamped
);
    logic [DW-1:0] sat_val;

    // Choose the value to store: full scale, zero, or the raw sample.
    always_comb begin
        if (ovr_hi)      sat_val = {DW{1'b1}};
        else if (ovr_lo) sat_val = {DW{1'b0}};
        else             sat_val = din;
    end

    // Flag the current sample as clamped.
    always_comb clamped = ovr_hi || ovr_lo;

    // Update the data register only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= sat_val;
    end

endmodule

// File: rtl/conv_seq.sv
// Conversion mode sequencer (top). Tracks the operating mode, gates the settle
// counter and the guard timer, and drives the ready and error flags.
// Flag priority within a cycle: mode write, then load, then guard start, then read.
// Assumes that ticks in continuous mode are spaced more than GUARD_CYC cycles apart.
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int DW          = 24,
    parameter int FIRST_TICKS = 2,
    parameter int GUARD_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [1:0]    mode_bits,
    input  logic          period_tick,
    input  logic          data_rd,
    input  logic          ovr_hi,
    input  logic          ovr_lo,
    input  logic [DW-1:0] conv_data,
    output logic          pwr_on,
    output logic          load_stb,
    output logic [DW-1:0] data_out,
    output logic          rdy,
    output logic          err
);
    seq_state_t state_q;
    logic       done, arm, fire, clamped;
    logic       starts_conv;

    // The converter is powered in both converting states.
    always_comb pwr_on = (state_q == ST_CONT) || (state_q == ST_SINGLE);
    always_comb load_stb = fire;
    // A mode write that does not select standby starts a conversion.
    always_comb starts_conv = mode_wr && !mode_bits[1];

    conv_seq_settle #(.FIRST_TICKS(FIRST_TICKS)) u_settle (
        .clk(clk), .rst_n(rst_n), .restart(mode_wr), .run(pwr_on),
        .tick(period_tick), .done(done)
    );

    conv_seq_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .restart(mode_wr), .done(done),
        .arm(arm), .fire(fire)
    );

    conv_seq_result #(.DW(DW)) u_result (
        .clk(clk), .rst_n(rst_n), .load(fire), .ovr_hi(ovr_hi),
        .ovr_lo(ovr_lo), .din(conv_data), .dout(data_out), .clamped(clamped)
    );

    // Mode state: follow mode writes, and power down after a single result.
    always_ff @(posedge clk) begin
        if (!rst_n)                             state_q <= ST_CONT;
        else if (mode_wr)                       state_q <= decode_mode(mode_bits);
        else if (fire && state_q == ST_SINGLE)  state_q <= ST_SDONE;
    end

    // Ready flag, using the fixed priority listed in the header.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy <= 1'b1;
        else if (mode_wr) rdy <= 1'b1;
        else if (fire)    rdy <= 1'b0;
        else if (arm)     rdy <= 1'b1;
        else if (data_rd) rdy <= 1'b1;
    end

    // Error flag: captured with each load, cleared by a conversion-starting write.
    always_ff @(posedge clk) begin
        if (!rst_n)           err <= 1'b0;
        else if (starts_conv) err <= 1'b0;
        else if (fire)        err <= clamped;
    end

endmodule

// File: rtl/conv_seq_chk.sv
// Checker for conv_seq: temporal properties on ports and mode state.
// It is attached by the bind statement at the end of this file.
module conv_seq_chk
    import conv_seq_pkg::*;
#(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_wr,
    input logic [1:0]    mode_bits,
    input logic          data_rd,
    input logic          ovr_hi,
    input logic          ovr_lo,
    input logic          load_stb,
    input logic          pwr_on,
    input logic [DW-1:0] data_out,
    input logic          rdy,
    input logic          err,
    input seq_state_t    state
);
    assert_load_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> pwr_on);

    assert_load_drops_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && !mode_wr |=> !rdy);

    assert_write_sets_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> rdy);

    assert_read_sets_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !load_stb && !mode_wr |=> rdy);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(data_out));

    assert_clamp_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && ovr_hi && !mode_wr |=> err && (data_out == {DW{1'b1}}));

    assert_clamp_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && ovr_lo && !ovr_hi && !mode_wr |=> err && (data_out == {DW{1'b0}}));

    assert_single_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && (state == ST_SINGLE) && !mode_wr |=> !pwr_on);

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && !mode_bits[1] |=> !err);

    assert_stby_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY) |-> rdy);

endmodule

bind conv_seq conv_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .data_rd(data_rd), .ovr_hi(ovr_hi), .ovr_lo(ovr_lo), .load_stb(load_stb),
    .pwr_on(pwr_on), .data_out(data_out), .rdy(rdy), .err(err), .state(state_q)
);

// File: tb/conv_seq_bench.sv
`timescale 1ns/1ps
module conv_seq_bench;
    localparam int DW = 24;
    localparam int G  = 4;

    typedef struct packed {
        logic          hi;
        logic          lo;
        logic [DW-1:0] din;
        logic [DW-1:0] exp;
        logic          eerr;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{hi:1'b0, lo:1'b0, din:24'hABCDEF, exp:24'hABCDEF, eerr:1'b0},
        '{hi:1'b1, lo:1'b0, din:24'h123456, exp:24'hFFFFFF, eerr:1'b1},
        '{hi:1'b0, lo:1'b0, din:24'h000001, exp:24'h000001, eerr:1'b0},
        '{hi:1'b0, lo:1'b1, din:24'h7FFFFF, exp:24'h000000, eerr:1'b1},
        '{hi:1'b1, lo:1'b1, din:24'h555555, exp:24'hFFFFFF, eerr:1'b1},
        '{hi:1'b1, lo:1'b0, din:24'h000000, exp:24'hFFFFFF, eerr:1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [1:0] mode_bits = 2'b00;
    logic period_tick = 1'b0;
    logic data_rd = 1'b0;
    logic ovr_hi = 1'b0;
    logic ovr_lo = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic pwr_on, load_stb, rdy, err;
    logic [DW-1:0] data_out;

    int checks = 0;
    int errors = 0;
    int nloads = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    conv_seq #(.DW(DW), .FIRST_TICKS(2), .GUARD_CYC(G)) u_conv_seq (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
        .period_tick(period_tick), .data_rd(data_rd), .ovr_hi(ovr_hi),
        .ovr_lo(ovr_lo), .conv_data(conv_data), .pwr_on(pwr_on),
        .load_stb(load_stb), .data_out(data_out), .rdy(rdy), .err(err)
    );

    always @(posedge clk) if (rst_n && load_stb) nloads <= nloads + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick;
        @(negedge clk) period_tick = 1'b1;
        @(negedge clk) period_tick = 1'b0;
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk) begin mode_wr = 1'b1; mode_bits = m; end
        @(negedge clk) mode_wr = 1'b0;
    endtask

    task automatic read_pulse;
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check(rdy == 1'b1 && err == 1'b0 && pwr_on == 1'b1 && load_stb == 1'b0, "R1 reset flags",
              {rdy, err, pwr_on, load_stb}, 4'b1010);
        check(data_out == '0, "R1 reset data", data_out, 0);

        // R2: the first tick after a restart gives no result
        conv_data = 24'h123456;
        pulse_tick;
        step(G + 2);
        check(nloads == 0, "R2 no load after first tick", nloads, 0);
        pulse_tick;
        check(rdy == 1'b1 && data_out == '0, "R4 guard rdy high before load", {rdy, data_out}, {1'b1, 24'h0});
        step(G - 1);
        check(load_stb == 1'b1, "R4 load strobe at guard end", load_stb, 1);
        step(1);
        check(data_out == 24'h123456 && rdy == 1'b0, "R2 first result on second tick", {rdy, data_out}, {1'b0, 24'h123456});
        check(nloads == 1, "R4 single load strobe", nloads, 1);

        // R6: a read sets rdy and keeps the data
        read_pulse;
        check(rdy == 1'b1 && data_out == 24'h123456, "R6 read sets rdy", {rdy, data_out}, {1'b1, 24'h123456});

        // R11: a read coinciding with a load; the load wins
        conv_data = 24'h0A0B0C;
        pulse_tick;
        step(G - 1);
        data_rd = 1'b1;
        step(1);
        data_rd = 1'b0;
        check(rdy == 1'b0 && data_out == 24'h0A0B0C, "R11 load beats read", {rdy, data_out}, {1'b0, 24'h0A0B0C});

        // R3 and R9: the table of subsequent conversions
        for (int i = 0; i < 6; i++) begin
            ovr_hi = VECS[i].hi;
            ovr_lo = VECS[i].lo;
            conv_data = VECS[i].din;
            base = nloads;
            pulse_tick;
            step(G);
            check(data_out == VECS[i].exp && err == VECS[i].eerr && rdy == 1'b0, "R9 clamp/data",
                  {err, data_out}, {VECS[i].eerr, VECS[i].exp});
            check(nloads == base + 1, "R3 one load per tick", nloads, base + 1);
            ovr_hi = 1'b0;
            ovr_lo = 1'b0;
        end

        // R8: standby; R10: a standby write keeps err
        base = nloads;
        write_mode(2'b10);
        check(pwr_on == 1'b0 && rdy == 1'b1 && err == 1'b1, "R10 standby keeps err", {pwr_on, rdy, err}, 3'b011);
        for (int k = 0; k < 3; k++) begin
            pulse_tick;
            step(G + 1);
        end
        check(nloads == base && data_out == 24'hFFFFFF && rdy == 1'b1, "R8 standby ignores ticks",
              {rdy, data_out}, {1'b1, 24'hFFFFFF});

        // R10: a continuous write clears err
        write_mode(2'b00);
        check(err == 1'b0 && pwr_on == 1'b1 && rdy == 1'b1, "R10 start clears err", {err, pwr_on, rdy}, 3'b011);

        // R7 and R11: a mode write inside the guard window cancels the load
        conv_data = 24'h111111;
        pulse_tick;
        pulse_tick;
        write_mode(2'b00);
        check(rdy == 1'b1, "R7 write sets rdy", rdy, 1);
        step(G + 2);
        check(nloads == base && data_out == 24'hFFFFFF, "R11 pending load cancelled", nloads, base);
        pulse_tick;
        step(G + 2);
        check(nloads == base, "R7 settle restarts", nloads, base);

        // R5: single conversion
        write_mode(2'b01);
        check(pwr_on == 1'b1, "R5 single powers up", pwr_on, 1);
        conv_data = 24'h2468AC;
        pulse_tick;
        step(G + 2);
        check(nloads == base, "R5 single no load after first tick", nloads, base);
        pulse_tick;
        step(G);
        check(data_out == 24'h2468AC && rdy == 1'b0 && pwr_on == 1'b0, "R5 single result and power down",
              {pwr_on, rdy, data_out}, {2'b00, 24'h2468AC});
        pulse_tick;
        pulse_tick;
        step(G + 1);
        check(nloads == base + 1 && rdy == 1'b0 && data_out == 24'h2468AC, "R5 single result held",
              {rdy, data_out}, {1'b0, 24'h2468AC});
        read_pulse;
        check(rdy == 1'b1 && data_out == 24'h2468AC, "R6 read after single", {rdy, data_out}, {1'b1, 24'h2468AC});
        write_mode(2'b01);
        check(pwr_on == 1'b1 && rdy == 1'b1, "R5 new single conversion", {pwr_on, rdy}, 2'b11);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule